// File: doc/BRIEF.md
# Multithreaded Reorder-Buffer Occupancy and Quota Unit

This block keeps the books for a reorder buffer shared by several hardware threads. It does not hold any instructions. It counts how many entries each thread occupies and how many are in use overall. From a sharing rule chosen at run time, it works out the most entries each thread may hold. Rename logic presents at most one allocation and one retirement per cycle, each tagged with a thread number. The block reports the free room per thread, the free room overall, and a per-thread stall flag that tells the front end to hold that thread back.

Three sharing rules exist:
- **Free-for-all:** any thread may use the whole buffer.
- **Even split:** the buffer is divided evenly among the threads that are running.
- **Fixed cap:** every thread gets a configured cap. A thread that runs alone gets the whole buffer.

The rule, the cap value and the running-thread mask are plain inputs. Per-thread limits follow any change of these within the same cycle. They are combinational, and the occupancy counters are not disturbed.

Top module: `rob_share_alloc`

## Requirements
- R1: After reset every thread count and the total are zero: `global_free` equals CAPACITY and each `thread_free` equals that thread's limit.
- R2: With `policy` 0 (free-for-all), or the unused code 3, every thread's limit is CAPACITY.
- R3: With `policy` 1 (even split), a thread whose `active_mask` bit is set gets CAPACITY / (number of set bits), using integer division. A thread whose bit is clear, or any thread when no bit is set, gets CAPACITY / NUM_THREADS.
- R4: With `policy` 2 (fixed cap), every thread's limit is `threshold` clamped to CAPACITY. When exactly one `active_mask` bit is set, that thread's limit is CAPACITY.
- R5: `thread_free[t]` (field t occupies bits t*W upward, W = width of `global_free`) is that thread's limit minus its count. It reads zero when the count exceeds the limit after a rule or mask change.
- R6: `global_free` is CAPACITY minus the sum of all thread counts, and the total never exceeds CAPACITY.
- R7: An accepted allocation raises the tagged thread's count by one at the next clock edge. A retirement lowers it by one.
- R8: `thread_stall[t]` is high exactly when `thread_free[t]` is zero or `global_free` is zero. An allocation for a stalled thread is dropped and changes no count.
- R9: An accepted allocation and a retirement for the same thread in the same cycle leave that thread's count and the total unchanged.
- R10: A retirement for a thread whose count is zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request this cycle |
| alloc_tid | input | TW | Thread of the allocation |
| retire_valid | input | 1 | Retirement this cycle |
| retire_tid | input | TW | Thread of the retirement |
| active_mask | input | NUM_THREADS | One bit per running thread |
| policy | input | 2 | 0 free-for-all, 1 even split, 2 fixed cap, 3 as 0 |
| threshold | input | W | Per-thread cap for the fixed-cap rule |
| thread_free | output | NUM_THREADS*W | Free room per thread, thread t at bits t*W |
| global_free | output | W | Free entries in the whole buffer |
| thread_stall | output | NUM_THREADS | Allocation for that thread would be refused |

## Verification
The bench builds the block with four threads and a capacity of twelve. Twelve divides into 3, 4, 6 and 12 for active counts of four, three, two and one, so every even-split share is a distinct, hand-checkable value. A 4-bit count width also lets a cap of 15 exercise the clamp. The small capacity lets a thread fill its quota, or the whole buffer, in a few cycles. This brings the global-stall case, the saturating free count after a mask shrink, and long random runs with frequent stalls within reach.

// File: rtl/rob_share_pkg.sv
package rob_share_pkg;

  typedef enum logic [1:0] {
    POL_OPEN  = 2'd0,
    POL_EVEN  = 2'd1,
    POL_CAP   = 2'd2,
    POL_SPARE = 2'd3
  } share_pol_e;

  // Integer share of a pool among n takers; n of zero keeps the pool.
  function automatic int share_of(input int pool, input int n);
    return (n <= 0) ? pool : pool / n;
  endfunction

  // Difference that never goes below zero.
  function automatic int floor_sub(input int a, input int b);
    return (a > b) ? a - b : 0;
  endfunction

  // Limit a value to a ceiling.
  function automatic int ceil_to(input int v, input int top);
    return (v > top) ? top : v;
  endfunction

endpackage

// File: rtl/rob_limit_calc.sv
module rob_limit_calc
  import rob_share_pkg::*;
#(
  parameter int NT  = 4,
  parameter int CAP = 32,
  parameter int CW  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  share_pol_e             pol,
  input  logic [CW-1:0]          thr,
  input  logic [NT-1:0]          act,
  output logic [NT-1:0][CW-1:0]  limit
);

  localparam int NW = $clog2(NT + 1);

  // even_share[k] : share when k threads run; k = 0 gives the idle split
  logic [CW-1:0] even_share [NT+1];
  for (genvar k = 0; k <= NT; k++) begin : g_share
    assign even_share[k] = CW'(share_of(CAP, (k == 0) ? NT : k));
  end

  logic [NW-1:0] n_act;
  logic [CW-1:0] thr_cl;

  always_comb begin
    n_act = '0;
    for (int i = 0; i < NT; i++) n_act = n_act + NW'(act[i]);
    thr_cl = CW'(ceil_to(int'(thr), CAP));
  end

  for (genvar t = 0; t < NT; t++) begin : g_lim
    always_comb begin
      unique case (pol)
        POL_EVEN: limit[t] = act[t] ? even_share[n_act] : even_share[0];
        POL_CAP:  limit[t] = (n_act == NW'(1) && act[t]) ? CW'(CAP) : thr_cl;
        default:  limit[t] = CW'(CAP);
      endcase
    end

    // R4: no rule ever grants a thread more than the whole buffer
    a_r4_limit_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
      int'(limit[t]) <= CAP);
  end

  // R3: the active threads' shares under even split fit in the buffer
  int act_sum;
  always_comb begin
    act_sum = 0;
    for (int i = 0; i < NT; i++) if (act[i]) act_sum += int'(limit[i]);
  end
  a_r3_even_fits: assert property (@(posedge clk) disable iff (!rst_n)
    pol == POL_EVEN |-> act_sum <= CAP);

endmodule

// File: rtl/rob_occupancy.sv
module rob_occupancy #(
  parameter int NT  = 4,
  parameter int CAP = 32,
  parameter int CW  = 6,
  parameter int TW  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_go,
  input  logic [TW-1:0]          alloc_tid,
  input  logic                   retire_req,
  input  logic [TW-1:0]          retire_tid,
  output logic [NT-1:0][CW-1:0]  cnt,
  output logic [CW-1:0]          total
);

  logic [NT-1:0] inc_hit;
  logic [NT-1:0] dec_hit;

  for (genvar t = 0; t < NT; t++) begin : g_cnt
    assign inc_hit[t] = alloc_go && (alloc_tid == TW'(t));
    assign dec_hit[t] = retire_req && (retire_tid == TW'(t)) && (cnt[t] != '0);

    always_ff @(posedge clk) begin
      if (!rst_n)                      cnt[t] <= '0;
      else if (inc_hit[t] && !dec_hit[t]) cnt[t] <= cnt[t] + 1'b1;
      else if (dec_hit[t] && !inc_hit[t]) cnt[t] <= cnt[t] - 1'b1;
    end

    // R7: lone allocation raises the count by one
    a_r7_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      inc_hit[t] && !(retire_req && retire_tid == TW'(t)) |=> cnt[t] == $past(cnt[t]) + 1'b1);
    // R7: lone retirement lowers a nonzero count by one
    a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      !inc_hit[t] && retire_req && retire_tid == TW'(t) && cnt[t] != '0
      |=> cnt[t] == $past(cnt[t]) - 1'b1);
    // R9: paired allocation and retirement leave the count alone
    a_r9_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
      inc_hit[t] && retire_req && retire_tid == TW'(t) && cnt[t] != '0 |=> $stable(cnt[t]));
    // R10: retiring from an empty thread does nothing
    a_r10_floor: assert property (@(posedge clk) disable iff (!rst_n)
      !inc_hit[t] && cnt[t] == '0 |=> cnt[t] == '0);
  end

  logic any_dec;
  assign any_dec = |dec_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)                 total <= '0;
    else if (alloc_go && !any_dec) total <= total + 1'b1;
    else if (any_dec && !alloc_go) total <= total - 1'b1;
  end

  // R6: the running total agrees with the per-thread counters
  int cnt_sum;
  always_comb begin
    cnt_sum = 0;
    for (int i = 0; i < NT; i++) cnt_sum += int'(cnt[i]);
  end
  a_r6_total_is_sum: assert property (@(posedge clk) disable iff (!rst_n)
    int'(total) == cnt_sum);

endmodule

// File: rtl/rob_share_alloc.sv
module rob_share_alloc
  import rob_share_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int CAPACITY    = 32,
  localparam int CW = $clog2(CAPACITY + 1),
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  input  logic [TW-1:0]             alloc_tid,
  input  logic                      retire_valid,
  input  logic [TW-1:0]             retire_tid,
  input  logic [NUM_THREADS-1:0]    active_mask,
  input  logic [1:0]                policy,
  input  logic [CW-1:0]             threshold,
  output logic [NUM_THREADS*CW-1:0] thread_free,
  output logic [CW-1:0]             global_free,
  output logic [NUM_THREADS-1:0]    thread_stall
);

  localparam int NT = NUM_THREADS;

  share_pol_e            pol;
  logic [NT-1:0][CW-1:0] limit;
  logic [NT-1:0][CW-1:0] cnt;
  logic [CW-1:0]         total;
  logic [NT-1:0][CW-1:0] free_v;
  logic                  sel_stall;
  logic                  tid_hit;
  logic                  alloc_go;

  assign pol = share_pol_e'(policy);

  rob_limit_calc #(.NT(NT), .CAP(CAPACITY), .CW(CW)) u_limit (
    .clk   (clk),
    .rst_n (rst_n),
    .pol   (pol),
    .thr   (threshold),
    .act   (active_mask),
    .limit (limit)
  );

  rob_occupancy #(.NT(NT), .CAP(CAPACITY), .CW(CW), .TW(TW)) u_occ (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_go   (alloc_go),
    .alloc_tid  (alloc_tid),
    .retire_req (retire_valid),
    .retire_tid (retire_tid),
    .cnt        (cnt),
    .total      (total)
  );

  assign global_free = CW'(CAPACITY) - total;

  for (genvar t = 0; t < NT; t++) begin : g_out
    assign free_v[t]                 = CW'(floor_sub(int'(limit[t]), int'(cnt[t])));
    assign thread_free[t*CW +: CW]   = free_v[t];
    assign thread_stall[t]           = (free_v[t] == '0) || (global_free == '0);

    // R5: free room never exceeds the thread's limit
    a_r5_free_le_limit: assert property (@(posedge clk) disable iff (!rst_n)
      free_v[t] <= limit[t]);
    // R8: a refused allocation leaves the thread's count where it was
    a_r8_stalled_drop: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid && alloc_tid == TW'(t) && thread_stall[t] &&
      !(retire_valid && retire_tid == TW'(t)) |=> $stable(cnt[t]));
  end

  always_comb begin
    sel_stall = 1'b1;
    tid_hit   = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (alloc_tid == TW'(t)) begin
        sel_stall = thread_stall[t];
        tid_hit   = 1'b1;
      end
    end
  end

  assign alloc_go = alloc_valid && tid_hit && !sel_stall;

  // R6: occupancy never passes the buffer size
  a_r6_never_over: assert property (@(posedge clk) disable iff (!rst_n)
    int'(total) <= CAPACITY);

endmodule

// File: tb/rob_share_alloc_bench.sv
`timescale 1ns/1ps
module rob_share_alloc_bench;

  localparam int NT  = 4;
  localparam int CAP = 12;
  localparam int CW  = 4;
  localparam int TW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0;
  logic [TW-1:0] alloc_tid = '0;
  logic retire_valid = 1'b0;
  logic [TW-1:0] retire_tid = '0;
  logic [NT-1:0] active_mask = '1;
  logic [1:0] policy = 2'd0;
  logic [CW-1:0] threshold = '0;
  logic [NT*CW-1:0] thread_free;
  logic [CW-1:0] global_free;
  logic [NT-1:0] thread_stall;

  always #10 clk = ~clk;

  rob_share_alloc #(.NUM_THREADS(NT), .CAPACITY(CAP)) u_rob_share_alloc (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid),
    .retire_valid(retire_valid), .retire_tid(retire_tid),
    .active_mask(active_mask), .policy(policy), .threshold(threshold),
    .thread_free(thread_free), .global_free(global_free), .thread_stall(thread_stall)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_cnt [NT];
  logic [NT-1:0] nx_mask = '1;
  logic [1:0] nx_pol = 2'd0;
  logic [CW-1:0] nx_thr = '0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_total();
    int s = 0;
    foreach (m_cnt[i]) s += m_cnt[i];
    return s;
  endfunction

  function automatic int exp_limit(input int t);
    int n = $countones(active_mask);
    case (policy)
      2'd1: begin
        if (n == 0 || !active_mask[t]) return CAP / NT;
        return CAP / n;
      end
      2'd2: begin
        if (n == 1 && active_mask[t]) return CAP;
        return (threshold > CAP) ? CAP : int'(threshold);
      end
      default: return CAP;
    endcase
  endfunction

  function automatic int exp_free(input int t);
    int d = exp_limit(t) - m_cnt[t];
    return (d < 0) ? 0 : d;
  endfunction

  function automatic int free_of(input int t);
    return int'(thread_free[t*CW +: CW]);
  endfunction

  task automatic model_update();
    bit acc;
    bit ret;
    int tot;
    tot = m_total();
    acc = alloc_valid && !(exp_free(alloc_tid) == 0 || tot >= CAP);
    ret = retire_valid && m_cnt[retire_tid] > 0;
    if (acc) m_cnt[alloc_tid]++;
    if (ret) m_cnt[retire_tid]--;
  endtask

  task automatic compare_all();
    int tot;
    tot = m_total();
    for (int t = 0; t < NT; t++) begin
      chk("R5 thread_free", free_of(t), exp_free(t));
      chk("R8 thread_stall", int'(thread_stall[t]),
          int'(exp_free(t) == 0 || tot >= CAP));
    end
    chk("R6 global_free", int'(global_free), CAP - tot);
  endtask

  // one cycle: fold in last edge, compare, then drive the next inputs
  task automatic step(input bit av, input int at, input bit rv, input int rt);
    @(negedge clk);
    model_update();
    compare_all();
    alloc_valid  = av;
    alloc_tid    = TW'(at);
    retire_valid = rv;
    retire_tid   = TW'(rt);
    active_mask  = nx_mask;
    policy       = nx_pol;
    threshold    = nx_thr;
  endtask

  task automatic idle();
    step(0, 0, 0, 0);
    #1;
  endtask

  task automatic allocs(input int t, input int n);
    for (int i = 0; i < n; i++) step(1, t, 0, 0);
  endtask

  task automatic retires(input int t, input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1, t);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    foreach (m_cnt[i]) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1 global_free", int'(global_free), CAP);
    for (int t = 0; t < NT; t++) chk("R1 thread_free", free_of(t), CAP);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: allocations raise counts
    allocs(0, 5); idle();
    chk("R7 thread0 free", free_of(0), 7);
    chk("R7 global_free", int'(global_free), 7);
    // R8: fill buffer, then a dropped allocation
    allocs(1, 7); idle();
    chk("R8 stall on full buffer", int'(thread_stall[2]), 1);
    allocs(2, 2); idle();
    chk("R8 dropped alloc", int'(global_free), 0);
    // R2: spare code behaves as free-for-all
    nx_pol = 2'd3; idle();
    chk("R2 spare code limit", free_of(2), 12);
    chk("R2 spare code busy thread", free_of(1), 5);
    nx_pol = 2'd0;
    // R7 retire, R10 retire from empty
    retires(0, 5); retires(1, 7); retires(0, 2); idle();
    chk("R10 empty retire ignored", int'(global_free), CAP);
    chk("R10 thread0 free", free_of(0), CAP);
    // R9: paired allocate and retire
    allocs(0, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0);
    idle();
    chk("R9 pair hold", free_of(0), 11);
    retires(0, 1);
    // R3: even split
    nx_pol = 2'd1; nx_mask = 4'b1111; idle();
    chk("R3 four active", free_of(1), 3);
    allocs(1, 4); idle();
    chk("R3 quota stall", int'(thread_stall[1]), 1);
    chk("R3 quota global", int'(global_free), 9);
    nx_mask = 4'b0111; idle();
    chk("R3 three active", free_of(1), 1);
    chk("R3 inactive share", free_of(3), 3);
    nx_mask = 4'b0011; idle();
    chk("R3 two active", free_of(1), 3);
    nx_mask = 4'b0001; idle();
    chk("R3 lone active", free_of(0), 12);
    chk("R3 dropped thread", free_of(1), 0);
    nx_mask = 4'b0000; idle();
    chk("R3 none active", free_of(0), 3);
    retires(1, 3);
    // R5: count above a shrunk limit
    nx_mask = 4'b0011; idle();
    allocs(0, 6); idle();
    nx_mask = 4'b1111; idle();
    chk("R5 saturated free", free_of(0), 0);
    retires(0, 6);
    // R4: fixed cap
    nx_pol = 2'd2; nx_thr = 4'd5; idle();
    chk("R4 cap value", free_of(2), 5);
    nx_mask = 4'b0100; idle();
    chk("R4 lone thread full", free_of(2), 12);
    chk("R4 other thread cap", free_of(0), 5);
    nx_mask = 4'b1111; nx_thr = 4'd15; idle();
    chk("R4 clamped cap", free_of(0), 12);

    // random traffic with changing configuration
    for (int i = 0; i < 3000; i++) begin
      if (i % 40 == 0) begin
        nx_pol  = 2'($urandom_range(3));
        nx_mask = NT'($urandom_range(15));
        nx_thr  = CW'($urandom_range(15));
      end
      step(($urandom_range(99) < 60), $urandom_range(NT - 1),
           ($urandom_range(99) < 45), $urandom_range(NT - 1));
    end
    idle();
    done = 1;
    summary();
    $finish;
  end

endmodule